// File: doc/BRIEF.md
# Jump Target and Condition Unit

This block decides, for each instruction presented to it, whether a control transfer happens and which address the fetch stage should use next. A direct jump carries a 26-bit word index. The unit splices that index under the top bits of the current program counter to form a word-aligned target. Six of the seven jump opcodes are conditional. Their conditions are evaluated against a three-bit status set (equal, greater-than, less-than) that the unit itself keeps.

That status set is written only by the compare instruction. The compare treats its two operands as signed 32-bit integers. The new flags are visible one clock after the compare is presented, and they stay unchanged until the next compare. The taken signal, the jump target and the next-PC are combinational from the current inputs and the stored flags. When no jump is taken, the next PC is the sequential address PC+4, which wraps modulo 2^32.

Top module: `jtu_unit`

## Requirements
- R1: While a jump opcode (0x0D to 0x13) is presented, `target` equals {pc[31:28], jfield[25:0], 2'b00}.
- R2: `next_pc` equals `target` when `taken` is high; otherwise it equals pc+4 modulo 2^32.
- R3: Opcode 0x0D makes `taken` high whatever the flag values are.
- R4: Opcode 0x0E is taken when the equal flag (`status[0]`) is set. Opcode 0x0F is taken when that flag is clear.
- R5: Opcode 0x10 is taken when the greater-than flag (`status[1]`) is set. Opcode 0x11 is taken when greater-than or equal is set.
- R6: Opcode 0x12 is taken when the less-than flag (`status[2]`) is set. Opcode 0x13 is taken when less-than or equal is set.
- R7: Opcode 0x14 compares `cmp_a` with `cmp_b` as signed values. On the following clock edge it sets exactly one of equal, greater-than (a>b) or less-than (a<b).
- R8: Synchronous reset clears all three flags. Any opcode other than 0x14 leaves the flags unchanged.
- R9: Any opcode outside 0x0D to 0x13 drives `taken` low, so `next_pc` is pc+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc | input | 32 | Address of the current instruction |
| opcode | input | 6 | Decoded opcode of the current instruction |
| jfield | input | 26 | Word index from a direct jump |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| taken | output | 1 | Control transfer happens this instruction |
| target | output | 32 | Spliced jump target |
| next_pc | output | 32 | Address to fetch next |
| status | output | 3 | Stored flags: bit0 equal, bit1 greater, bit2 less |

## Verification
`taken`, `target` and `next_pc` are due in the same cycle as the opcode and PC that produce them. The bench drives the inputs on the falling edge and samples these outputs one time unit later, before any rising edge. A compare has its effect only at the next rising edge. The bench therefore checks `status` and the conditional jumps that depend on it at the falling edge that follows. This also shows that the flags did not change while the compare was merely presented.

// File: rtl/jtu_pkg.sv
package jtu_pkg;
    localparam int XLEN     = 32;
    localparam int OPC_W    = 6;
    localparam int FIELD_W  = 26;

    typedef enum logic [OPC_W-1:0] {
        OP_JMP = 6'h0D,
        OP_JEQ = 6'h0E,
        OP_JNE = 6'h0F,
        OP_JGT = 6'h10,
        OP_JGE = 6'h11,
        OP_JLT = 6'h12,
        OP_JLE = 6'h13,
        OP_CMP = 6'h14
    } jtu_op_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
    } jtu_flags_t;

    function automatic logic is_jump(input logic [OPC_W-1:0] op);
        return (op >= OP_JMP) && (op <= OP_JLE);
    endfunction

    function automatic logic cond_met(input logic [OPC_W-1:0] op,
                                      input jtu_flags_t f);
        logic r;
        case (op)
            OP_JMP:  r = 1'b1;
            OP_JEQ:  r = f.eq;
            OP_JNE:  r = !f.eq;
            OP_JGT:  r = f.gt;
            OP_JGE:  r = f.gt | f.eq;
            OP_JLT:  r = f.lt;
            OP_JLE:  r = f.lt | f.eq;
            default: r = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/jtu_flags.sv
module jtu_flags
    import jtu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmp_en,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output jtu_flags_t   flags
);
    jtu_flags_t nxt;

    always_comb begin
        nxt.eq = (a == b);
        nxt.gt = ($signed(a) > $signed(b));
        nxt.lt = ($signed(a) < $signed(b));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (cmp_en) begin
            flags <= nxt;
        end
    end
endmodule

// File: rtl/jtu_cond.sv
module jtu_cond
    import jtu_pkg::*;
(
    input  logic [OPC_W-1:0] op,
    input  jtu_flags_t       flags,
    output logic             taken
);
    always_comb begin
        taken = is_jump(op) && cond_met(op, flags);
    end
endmodule

// File: rtl/jtu_target.sv
module jtu_target #(
    parameter int AW = 32,
    parameter int FW = 26
) (
    input  logic [AW-1:0] pc,
    input  logic [FW-1:0] field,
    output logic [AW-1:0] target,
    output logic [AW-1:0] seq
);
    localparam int REGION_W = AW - FW - 2;
    localparam logic [AW-1:0] STEP = AW'(4);

    generate
        if (REGION_W > 0) begin : g_region
            assign target = {pc[AW-1 -: REGION_W], field, 2'b00};
        end else begin : g_flat
            assign target = {field[AW-3:0], 2'b00};
        end
    endgenerate

    assign seq = pc + STEP;
endmodule

// File: rtl/jtu_unit.sv
module jtu_unit
    import jtu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [XLEN-1:0]    pc,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [FIELD_W-1:0] jfield,
    input  logic [XLEN-1:0]    cmp_a,
    input  logic [XLEN-1:0]    cmp_b,
    output logic               taken,
    output logic [XLEN-1:0]    target,
    output logic [XLEN-1:0]    next_pc,
    output logic [2:0]         status
);
    jtu_flags_t       flags_q;
    logic [XLEN-1:0]  seq_pc;
    logic             cmp_en;

    assign cmp_en = (opcode == OP_CMP);

    jtu_flags #(.W(XLEN)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .cmp_en (cmp_en),
        .a      (cmp_a),
        .b      (cmp_b),
        .flags  (flags_q)
    );

    jtu_cond u_cond (
        .op    (opcode),
        .flags (flags_q),
        .taken (taken)
    );

    jtu_target #(.AW(XLEN), .FW(FIELD_W)) u_target (
        .pc     (pc),
        .field  (jfield),
        .target (target),
        .seq    (seq_pc)
    );

    assign next_pc = taken ? target : seq_pc;
    assign status  = flags_q;
endmodule

// File: rtl/jtu_unit_chk.sv
module jtu_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [5:0]  opcode,
    input logic [25:0] jfield,
    input logic [31:0] cmp_a,
    input logic [31:0] cmp_b,
    input logic        taken,
    input logic [31:0] target,
    input logic [31:0] next_pc,
    input logic [2:0]  status
);
    logic is_j;
    assign is_j = (opcode >= 6'h0D) && (opcode <= 6'h13);

    assert_target_splice_R1: assert property (@(posedge clk) disable iff (rst)
        is_j |-> (target == {pc[31:28], jfield, 2'b00}));

    assert_seq_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !taken |-> (next_pc == pc + 32'd4));

    assert_uncond_R3: assert property (@(posedge clk) disable iff (rst)
        (opcode == 6'h0D) |-> taken);

    assert_one_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (opcode == 6'h14) |=> ($countones(status) == 1));

    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (opcode != 6'h14) |=> $stable(status));

    assert_nonjump_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !is_j |-> !taken);
endmodule

bind jtu_unit jtu_unit_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc      (pc),
    .opcode  (opcode),
    .jfield  (jfield),
    .cmp_a   (cmp_a),
    .cmp_b   (cmp_b),
    .taken   (taken),
    .target  (target),
    .next_pc (next_pc),
    .status  (status)
);

// File: tb/tb_jtu_unit.sv
`timescale 1ns/1ps
module tb_jtu_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] pc;
    logic [5:0]  opcode;
    logic [25:0] jfield;
    logic [31:0] cmp_a, cmp_b;
    logic        taken;
    logic [31:0] target, next_pc;
    logic [2:0]  status;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    jtu_unit dut (
        .clk(clk), .rst(rst), .pc(pc), .opcode(opcode), .jfield(jfield),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .taken(taken), .target(target),
        .next_pc(next_pc), .status(status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference taken decision written from R3..R6, R9; flags {lt,gt,eq}
    function automatic logic ref_taken(input logic [5:0] op, input logic [2:0] f);
        case (op)
            6'h0D: return 1'b1;
            6'h0E: return f[0];
            6'h0F: return !f[0];
            6'h10: return f[1];
            6'h11: return f[1] | f[0];
            6'h12: return f[2];
            6'h13: return f[2] | f[0];
            default: return 1'b0;
        endcase
    endfunction

    // Present one instruction at the falling edge, sample 1 ns later
    task automatic present(input logic [5:0] op, input logic [31:0] p, input logic [25:0] f);
        @(negedge clk);
        opcode = op; pc = p; jfield = f;
        #1;
    endtask

    task automatic do_compare(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        opcode = 6'h14; cmp_a = a; cmp_b = b;
        @(negedge clk);
        opcode = 6'h00;
        #1;
    endtask

    task automatic sweep_jumps(input logic [2:0] f, input string tag);
        for (int op = 6'h0D; op <= 6'h13; op++) begin
            logic [31:0] p;
            logic [31:0] tg;
            logic        t;
            p  = 32'h5000_0100 + 32'(op * 4);
            present(6'(op), p, 26'h0ABCDE);
            t  = ref_taken(6'(op), f);
            tg = {p[31:28], 26'h0ABCDE, 2'b00};
            chk({tag, " taken"}, {31'b0, taken}, {31'b0, t});
            chk("R2 next_pc", next_pc, t ? tg : p + 32'd4);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; opcode = 6'h00; pc = 0; jfield = 0; cmp_a = 0; cmp_b = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R8 reset flags", {29'b0, status}, 32'd0);
        sweep_jumps(3'b000, "R4/R5/R6 after reset");
    endtask

    task automatic t_target;
        present(6'h0D, 32'hA000_1234, 26'h3FF_FFFF);
        chk("R1 target all-ones field", target, 32'hAFFF_FFFC);
        chk("R3 jmp taken", {31'b0, taken}, 32'd1);
        chk("R2 next_pc jmp", next_pc, 32'hAFFF_FFFC);
        present(6'h0D, 32'h3FFF_FFFC, 26'h000_0000);
        chk("R1 target zero field", target, 32'h3000_0000);
    endtask

    task automatic t_compare;
        do_compare(32'd5, 32'd5);
        chk("R7 equal", {29'b0, status}, 32'b001);
        sweep_jumps(3'b001, "R4 R5 R6 eq");
        do_compare(32'hFFFF_FFFF, 32'd1);
        chk("R7 signed less", {29'b0, status}, 32'b100);
        sweep_jumps(3'b100, "R6 lt");
        do_compare(32'h7FFF_FFFF, 32'h8000_0000);
        chk("R7 signed greater", {29'b0, status}, 32'b010);
        sweep_jumps(3'b010, "R5 gt");
    endtask

    task automatic t_hold;
        // flags are gt from previous compare; other opcodes with new operands must not touch them
        @(negedge clk);
        cmp_a = 32'd0; cmp_b = 32'd0;
        opcode = 6'h19;
        @(negedge clk);
        opcode = 6'h0E;
        @(negedge clk);
        #1;
        chk("R8 flags held", {29'b0, status}, 32'b010);
        chk("R8 jeq still not taken", {31'b0, taken}, 32'd0);
    endtask

    task automatic t_nonjump;
        present(6'h14, 32'hFFFF_FFFC, 26'h1);
        chk("R9 cmp not taken", {31'b0, taken}, 32'd0);
        chk("R9 wrap next_pc", next_pc, 32'h0000_0000);
        present(6'h00, 32'h0000_0040, 26'h1);
        chk("R9 nop next_pc", next_pc, 32'h0000_0044);
        present(6'h0C, 32'h0000_0040, 26'h1);
        chk("R9 below range", {31'b0, taken}, 32'd0);
        present(6'h3F, 32'h0000_0080, 26'h1);
        chk("R9 top opcode", next_pc, 32'h0000_0084);
    endtask

    initial begin : watchdog
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset;
        t_target;
        t_compare;
        t_hold;
        t_nonjump;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule